// File: doc/BRIEF.md
# Receive Flow-Control and Special-Character Matcher

This block sits between the character output of a serial receiver and the receive FIFO. Each received byte is compared with four programmable flow-control characters (two resume codes and two pause codes) and, when enabled, with a special-character value. The block decides whether the byte is written into the FIFO or swallowed. It keeps a transmit-halt level that a transmitter uses to pause and resume. It also raises sticky pause, resume and special-character flags, which are combined into one interrupt line through two enables.

A two-bit compare mode selects the behaviour. In the off mode, every byte passes through. In the first-pair mode, a single byte is matched against the first resume and pause codes. In the second-pair mode, it is matched against the second resume and pause codes. In the sequence mode, a flow-control event needs the first code of a pair immediately followed by the second code of the same pair. The special-character compare reuses the second pause register. When the second-pair mode is active, a byte equal to that register is a pause character: it is swallowed and raises both the pause and the special flag. In every other mode such a byte is stored and flagged.

Top module: `rx_flow_matcher`

## Requirements
- R1: After reset, fifo_we, tx_halt, all three flags and irq are 0.
- R2: With cmp_mode 2'b00, every received byte is written to the FIFO unchanged one cycle after its strobe, and tx_halt and the pause/resume flags do not change.
- R3: With cmp_mode 2'b10, a byte equal to xon1_chr or xoff1_chr is not written. An xoff1_chr byte sets tx_halt and xoff_flag, and an xon1_chr byte clears tx_halt and sets xon_flag. All other bytes are written. Bit 0 of every compare register matches bit 0 of the received byte.
- R4: With cmp_mode 2'b01, the same rule as R3 applies using xon2_chr and xoff2_chr.
- R5: With cmp_mode 2'b11, xoff1_chr followed directly by xoff2_chr sets tx_halt and xoff_flag, and xon1_chr followed directly by xon2_chr clears tx_halt and sets xon_flag. In both cases neither byte is written.
- R6: With cmp_mode 2'b11, a held first code that is not followed by its partner is written to the FIFO when the next byte arrives. That next byte is then judged afresh one cycle later, so it is written, held, or completes a pair.
- R7: With spec_en 1 and cmp_mode 2'b00, 2'b10 or 2'b11, a byte equal to xoff2_chr that is not otherwise swallowed is written and sets spec_flag. With spec_en 0, spec_flag is never set.
- R8: With spec_en 1 and cmp_mode 2'b01, a byte equal to xoff2_chr is not written. It sets xoff_flag, spec_flag and tx_halt.
- R9: irq is 1 exactly when (xoff_flag or xon_flag) and ie_flow, or spec_flag and ie_spec.
- R10: Flags stay set until a flag_clr pulse clears them. A flag set by a byte in the same cycle as flag_clr stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_data | input | DW | Received byte, bit 0 first on the line |
| xon1_chr | input | DW | First resume code |
| xon2_chr | input | DW | Second resume code |
| xoff1_chr | input | DW | First pause code |
| xoff2_chr | input | DW | Second pause code, also the special character |
| cmp_mode | input | 2 | 00 off, 10 first pair, 01 second pair, 11 sequence |
| spec_en | input | 1 | Special-character detect enable |
| ie_flow | input | 1 | Interrupt enable for pause/resume flags |
| ie_spec | input | 1 | Interrupt enable for the special flag |
| flag_clr | input | 1 | Clear-on-read pulse for all flags |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_wdata | output | DW | FIFO write data |
| tx_halt | output | 1 | Transmitter pause level |
| xoff_flag | output | 1 | Sticky pause-received flag |
| xon_flag | output | 1 | Sticky resume-received flag |
| spec_flag | output | 1 | Sticky special-character flag |
| irq | output | 1 | Combined interrupt |

## Verification
A byte strobed in cycle k produces its FIFO write, flag update and halt change in cycle k+1. The exception is a broken sequence in mode 11: the held code is written in k+1 and the re-judged byte takes effect in k+2. irq follows the flags in the same cycle. The bench spaces strobes four cycles apart and compares halt, flags and irq three falling edges after each strobe, when every result is due. FIFO writes are checked on every falling edge against a queue of expected bytes, which catches both missing writes and extra writes.

// File: rtl/rfm_pkg.sv
// Package: shared types and constants for the receive flow-control matcher.
// Assumes byte-wide characters unless the top overrides DW.
package rfm_pkg;
    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_XOFF = 2'd1,
        PEND_XON  = 2'd2
    } pend_t;

    localparam logic [1:0] MODE_OFF  = 2'b00;
    localparam logic [1:0] MODE_P2   = 2'b01;
    localparam logic [1:0] MODE_P1   = 2'b10;
    localparam logic [1:0] MODE_SEQ  = 2'b11;

    localparam int NFLAG    = 3;
    localparam int FLG_XOFF = 0;
    localparam int FLG_XON  = 1;
    localparam int FLG_SPEC = 2;

    typedef struct packed {
        logic  wr_in;    // write the byte under judgement
        logic  wr_pend;  // write the held first code
        logic  ev_xoff;  // pause event
        logic  ev_xon;   // resume event
        logic  spec;     // special character seen
        logic  replay;   // judge this byte again next cycle
        pend_t pend_nxt; // next held-code state
    } act_t;
endpackage

// File: rtl/rfm_classify.sv
// Module: rfm_classify
// Judges one byte against the compare registers under the active mode and
// returns the action. Purely combinational; holds no state.
// Assumes the four flow-control codes are programmed to distinct values.
module rfm_classify
    import rfm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          in_v,
    input  logic [DW-1:0] in_d,
    input  logic [1:0]    mode,
    input  pend_t         pend,
    input  logic [DW-1:0] xon1_chr,
    input  logic [DW-1:0] xon2_chr,
    input  logic [DW-1:0] xoff1_chr,
    input  logic [DW-1:0] xoff2_chr,
    input  logic          spec_en,
    output act_t          act
);
    logic hit_on1, hit_on2, hit_off1, hit_off2;

    // Equality of the byte with each compare register, bit 0 to bit 0.
    always_comb begin
        hit_on1  = (in_d == xon1_chr);
        hit_on2  = (in_d == xon2_chr);
        hit_off1 = (in_d == xoff1_chr);
        hit_off2 = (in_d == xoff2_chr);
    end

    // Decide the fate of the byte for the active mode and held-code state.
    always_comb begin
        act          = '0;
        act.pend_nxt = pend;
        if (in_v) begin
            act.spec = spec_en && hit_off2;
            unique case (mode)
                MODE_OFF: act.wr_in = 1'b1;
                MODE_P1: begin
                    if (hit_off1)      act.ev_xoff = 1'b1;
                    else if (hit_on1)  act.ev_xon  = 1'b1;
                    else               act.wr_in   = 1'b1;
                end
                MODE_P2: begin
                    if (hit_off2)      act.ev_xoff = 1'b1;
                    else if (hit_on2)  act.ev_xon  = 1'b1;
                    else               act.wr_in   = 1'b1;
                end
                default: begin
                    unique case (pend)
                        PEND_XOFF: begin
                            act.pend_nxt = PEND_NONE;
                            if (hit_off2) begin
                                act.ev_xoff = 1'b1;
                            end else begin
                                act.wr_pend = 1'b1;
                                act.replay  = 1'b1;
                                act.spec    = 1'b0;
                            end
                        end
                        PEND_XON: begin
                            act.pend_nxt = PEND_NONE;
                            if (hit_on2) begin
                                act.ev_xon = 1'b1;
                            end else begin
                                act.wr_pend = 1'b1;
                                act.replay  = 1'b1;
                                act.spec    = 1'b0;
                            end
                        end
                        default: begin
                            if (hit_off1)      act.pend_nxt = PEND_XOFF;
                            else if (hit_on1)  act.pend_nxt = PEND_XON;
                            else               act.wr_in    = 1'b1;
                        end
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/rfm_track.sv
// Module: rfm_track
// Holds the sequence-mode held code, the replay byte, the transmit-halt
// level and the sticky flags. Synchronous active-low reset to zero.
// Assumes at most one byte is judged per cycle.
module rfm_track
    import rfm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_v,
    input  logic [DW-1:0]    in_d,
    input  logic [1:0]       mode,
    input  act_t             act,
    input  logic             flag_clr,
    output pend_t            pend,
    output logic             replay_v,
    output logic [DW-1:0]    replay_d,
    output logic             tx_halt,
    output logic [NFLAG-1:0] flags
);
    logic [NFLAG-1:0] flag_set;

    // Held first code of a pair; dropped when the mode leaves sequence mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                pend <= PEND_NONE;
        else if (mode != MODE_SEQ) pend <= PEND_NONE;
        else if (in_v)             pend <= act.pend_nxt;
    end

    // Byte to re-judge one cycle after a broken sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            replay_v <= 1'b0;
            replay_d <= '0;
        end else begin
            replay_v <= act.replay;
            if (act.replay) replay_d <= in_d;
        end
    end

    // Transmit-halt level: pause sets, resume clears.
    always_ff @(posedge clk) begin
        if (!rst_n)           tx_halt <= 1'b0;
        else if (act.ev_xoff) tx_halt <= 1'b1;
        else if (act.ev_xon)  tx_halt <= 1'b0;
    end

    // Gather the per-flag set requests.
    always_comb begin
        flag_set           = '0;
        flag_set[FLG_XOFF] = act.ev_xoff;
        flag_set[FLG_XON]  = act.ev_xon;
        flag_set[FLG_SPEC] = act.spec;
    end

    // One sticky flag per event; set wins over a clear in the same cycle.
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)           flags[g] <= 1'b0;
            else if (flag_set[g]) flags[g] <= 1'b1;
            else if (flag_clr)    flags[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_flow_matcher.sv
// Module: rx_flow_matcher (top)
// Filters received bytes into the FIFO, swallowing flow-control codes of
// the active compare set, and keeps halt level, flags and interrupt.
// Assumes rx_valid strobes are at least two cycles apart so a replayed byte
// never meets a new strobe; the compare registers are static while bytes flow.
module rx_flow_matcher
    import rfm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic [DW-1:0] xon1_chr,
    input  logic [DW-1:0] xon2_chr,
    input  logic [DW-1:0] xoff1_chr,
    input  logic [DW-1:0] xoff2_chr,
    input  logic [1:0]    cmp_mode,
    input  logic          spec_en,
    input  logic          ie_flow,
    input  logic          ie_spec,
    input  logic          flag_clr,
    output logic          fifo_we,
    output logic [DW-1:0] fifo_wdata,
    output logic          tx_halt,
    output logic          xoff_flag,
    output logic          xon_flag,
    output logic          spec_flag,
    output logic          irq
);
    logic             in_v;
    logic [DW-1:0]    in_d;
    pend_t            pend;
    logic             replay_v;
    logic [DW-1:0]    replay_d;
    logic [NFLAG-1:0] flags;
    act_t             act;
    logic [DW-1:0]    pend_byte;

    // Pick the byte to judge: a replayed byte or the fresh strobe.
    always_comb begin
        in_v = rx_valid | replay_v;
        in_d = replay_v ? replay_d : rx_data;
    end

    rfm_classify #(.DW(DW)) i_classify (
        .in_v      (in_v),
        .in_d      (in_d),
        .mode      (cmp_mode),
        .pend      (pend),
        .xon1_chr  (xon1_chr),
        .xon2_chr  (xon2_chr),
        .xoff1_chr (xoff1_chr),
        .xoff2_chr (xoff2_chr),
        .spec_en   (spec_en),
        .act       (act)
    );

    rfm_track #(.DW(DW)) i_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_v     (in_v),
        .in_d     (in_d),
        .mode     (cmp_mode),
        .act      (act),
        .flag_clr (flag_clr),
        .pend     (pend),
        .replay_v (replay_v),
        .replay_d (replay_d),
        .tx_halt  (tx_halt),
        .flags    (flags)
    );

    // Value of the held first code, rebuilt from its register.
    always_comb pend_byte = (pend == PEND_XON) ? xon1_chr : xoff1_chr;

    // Registered FIFO write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_we    <= 1'b0;
            fifo_wdata <= '0;
        end else begin
            fifo_we <= act.wr_in | act.wr_pend;
            if (act.wr_pend)    fifo_wdata <= pend_byte;
            else if (act.wr_in) fifo_wdata <= in_d;
        end
    end

    // Flag outputs and the gated interrupt.
    always_comb begin
        xoff_flag = flags[FLG_XOFF];
        xon_flag  = flags[FLG_XON];
        spec_flag = flags[FLG_SPEC];
        irq       = (ie_flow & (xoff_flag | xon_flag)) | (ie_spec & spec_flag);
    end
endmodule

// File: rtl/rx_flow_matcher_chk.sv
// Module: rx_flow_matcher_chk
// Port-level temporal checks for rx_flow_matcher, attached by bind below.
// Assumes compare registers and mode are static while bytes are strobed.
module rx_flow_matcher_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic [DW-1:0] rx_data,
    input logic [DW-1:0] xon1_chr,
    input logic [DW-1:0] xon2_chr,
    input logic [DW-1:0] xoff1_chr,
    input logic [DW-1:0] xoff2_chr,
    input logic [1:0]    cmp_mode,
    input logic          spec_en,
    input logic          ie_flow,
    input logic          ie_spec,
    input logic          flag_clr,
    input logic          fifo_we,
    input logic [DW-1:0] fifo_wdata,
    input logic          tx_halt,
    input logic          xoff_flag,
    input logic          irq
);
    AST_OFF_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_mode == 2'b00 && rx_valid) |=> (fifo_we && fifo_wdata == $past(rx_data))); // R2

    AST_PAIR1_SWALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_mode == 2'b10 && rx_valid && (rx_data == xoff1_chr || rx_data == xon1_chr)) |=> !fifo_we); // R3

    AST_PAIR2_SWALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_mode == 2'b01 && rx_valid && (rx_data == xoff2_chr || rx_data == xon2_chr)) |=> !fifo_we); // R4

    AST_HALT_NEEDS_XOFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_halt) |-> xoff_flag); // R5

    AST_SPEC_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_mode == 2'b10 && spec_en && rx_valid && rx_data == xoff2_chr
         && rx_data != xoff1_chr && rx_data != xon1_chr) |=> fifo_we); // R7

    AST_SPEC_AS_XOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_mode == 2'b01 && spec_en && rx_valid && rx_data == xoff2_chr)
        |=> (!fifo_we && xoff_flag && tx_halt)); // R8

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_flow && !ie_spec) |-> !irq); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (xoff_flag && !flag_clr) |=> xoff_flag); // R10
endmodule

bind rx_flow_matcher rx_flow_matcher_chk #(.DW(DW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .xon1_chr   (xon1_chr),
    .xon2_chr   (xon2_chr),
    .xoff1_chr  (xoff1_chr),
    .xoff2_chr  (xoff2_chr),
    .cmp_mode   (cmp_mode),
    .spec_en    (spec_en),
    .ie_flow    (ie_flow),
    .ie_spec    (ie_spec),
    .flag_clr   (flag_clr),
    .fifo_we    (fifo_we),
    .fifo_wdata (fifo_wdata),
    .tx_halt    (tx_halt),
    .xoff_flag  (xoff_flag),
    .irq        (irq)
);

// File: tb/test_rx_flow_matcher.sv
// Bench: directed corners plus seeded random bytes against a bench model.
module test_rx_flow_matcher;
    localparam int DW = 8;
    localparam logic [7:0] C_ON1 = 8'h11, C_OFF1 = 8'h13, C_ON2 = 8'h91, C_OFF2 = 8'h93;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_valid = 1'b0, spec_en = 1'b0, ie_flow = 1'b0, ie_spec = 1'b0, flag_clr = 1'b0;
    logic [7:0] rx_data = '0;
    logic [1:0] cmp_mode = 2'b00;
    logic fifo_we, tx_halt, xoff_flag, xon_flag, spec_flag, irq;
    logic [7:0] fifo_wdata;

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    int m_pend = 0;
    logic m_halt = 0, m_fx = 0, m_fn = 0, m_fs = 0;

    always #10 clk = ~clk;

    rx_flow_matcher #(.DW(DW)) i_rx_flow_matcher (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .xon1_chr(C_ON1), .xon2_chr(C_ON2), .xoff1_chr(C_OFF1), .xoff2_chr(C_OFF2),
        .cmp_mode(cmp_mode), .spec_en(spec_en), .ie_flow(ie_flow), .ie_spec(ie_spec),
        .flag_clr(flag_clr), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata),
        .tx_halt(tx_halt), .xoff_flag(xoff_flag), .xon_flag(xon_flag),
        .spec_flag(spec_flag), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic string mode_req();
        case (cmp_mode)
            2'b00:   return "R2";
            2'b10:   return "R3";
            2'b01:   return "R4";
            default: return "R5_R6";
        endcase
    endfunction

    // Write monitor: every FIFO write must match the next expected byte.
    always @(negedge clk) begin
        if (rst_n && fifo_we) begin
            if (exp_q.size() == 0) chk({mode_req(), " unexpected write"}, {24'h0, fifo_wdata}, 32'hFFFF);
            else chk({mode_req(), " write data"}, {24'h0, fifo_wdata}, {24'h0, exp_q.pop_front()});
        end
    end

    // Bench model of one judged byte.
    task automatic model(input logic [7:0] d, input logic clr);
        logic sx = 0, sn = 0, ss = 0;
        if (cmp_mode == 2'b11 && m_pend != 0) begin
            if (m_pend == 1 && d == C_OFF2) begin sx = 1; m_pend = 0; ss = spec_en; end
            else if (m_pend == 2 && d == C_ON2) begin sn = 1; m_pend = 0; end
            else begin
                exp_q.push_back(m_pend == 1 ? C_OFF1 : C_ON1);   // R6 held code released
                m_pend = 0;
            end
        end
        if (!sx && !sn) begin
            ss = spec_en && d == C_OFF2;
            case (cmp_mode)
                2'b00: exp_q.push_back(d);
                2'b10: if (d == C_OFF1) sx = 1; else if (d == C_ON1) sn = 1; else exp_q.push_back(d);
                2'b01: if (d == C_OFF2) sx = 1; else if (d == C_ON2) sn = 1; else exp_q.push_back(d);
                default: if (d == C_OFF1) m_pend = 1; else if (d == C_ON1) m_pend = 2; else exp_q.push_back(d);
            endcase
        end
        if (sx) m_halt = 1; else if (sn) m_halt = 0;
        m_fx = sx | (m_fx & ~clr);
        m_fn = sn | (m_fn & ~clr);
        m_fs = ss | (m_fs & ~clr);
    endtask

    task automatic check_state(input string req);
        chk({req, " tx_halt"}, {31'h0, tx_halt}, {31'h0, m_halt});
        chk({req, " flags"}, {29'h0, spec_flag, xon_flag, xoff_flag}, {29'h0, m_fs, m_fn, m_fx});
        chk("R9 irq", {31'h0, irq}, {31'h0, ((m_fx | m_fn) & ie_flow) | (m_fs & ie_spec)});
    endtask

    task automatic send(input logic [7:0] d, input logic clr, input string req);
        model(d, clr);
        rx_valid = 1'b1; rx_data = d; flag_clr = clr;
        @(negedge clk);
        rx_valid = 1'b0; flag_clr = 1'b0;
        repeat (3) @(negedge clk);
        check_state(req);
    endtask

    task automatic clear_flags();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        m_fx = 0; m_fn = 0; m_fs = 0;
        @(negedge clk);
        check_state("R10 clear");
    endtask

    task automatic set_mode(input logic [1:0] m);
        cmp_mode = m;
        m_pend = 0;
        repeat (2) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {26'h0, fifo_we, tx_halt, xoff_flag, xon_flag, spec_flag, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        ie_flow = 1'b1; ie_spec = 1'b1;

        // R2: pass-through, flow codes included.
        send(C_OFF1, 0, "R2"); send(8'h41, 0, "R2");
        // R3: first pair, bit-exact compare (0x12 differs from 0x13 in bit 0).
        set_mode(2'b10);
        send(C_OFF1, 0, "R3"); send(8'h12, 0, "R3"); send(C_ON1, 0, "R3");
        // R4: second pair.
        set_mode(2'b01);
        send(C_OFF2, 0, "R4"); send(C_ON2, 0, "R4"); send(C_OFF1, 0, "R4");
        clear_flags();
        // R8: special shares the second pause code.
        spec_en = 1'b1;
        send(C_OFF2, 0, "R8");
        clear_flags();
        // R7: special stored in first-pair mode; R10 set wins over clear.
        set_mode(2'b10);
        send(C_OFF2, 0, "R7");
        send(C_ON1, 1, "R10 set beats clear");
        spec_en = 1'b0;
        send(C_OFF2, 0, "R7 disabled");
        // R5, R6: sequences.
        set_mode(2'b11);
        send(C_OFF1, 0, "R5"); send(C_OFF2, 0, "R5");
        send(C_ON1, 0, "R5");  send(C_ON2, 0, "R5");
        send(C_OFF1, 0, "R6"); send(8'h41, 0, "R6");
        send(C_ON1, 0, "R6");  send(C_OFF1, 0, "R6"); send(C_OFF2, 0, "R6");
        // R9: interrupt gating.
        ie_flow = 1'b0; ie_spec = 1'b0;
        @(negedge clk); check_state("R9");
        ie_spec = 1'b1;
        @(negedge clk); check_state("R9");

        // Random phase over all modes.
        for (int m = 0; m < 4; m++) begin
            set_mode(2'(m));
            for (int i = 0; i < 80; i++) begin
                logic [7:0] d;
                int pick = $urandom_range(0, 7);
                case (pick)
                    0: d = C_ON1; 1: d = C_ON2; 2: d = C_OFF1; 3: d = C_OFF2;
                    default: d = 8'($urandom_range(0, 255));
                endcase
                spec_en = 1'($urandom_range(0, 1));
                ie_flow = 1'($urandom_range(0, 1));
                ie_spec = 1'($urandom_range(0, 1));
                send(d, ($urandom_range(0, 9) == 0), mode_req());
            end
        end
        set_mode(2'b00);
        repeat (3) @(negedge clk);
        chk("R6 no write left pending", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule